// File: doc/BRIEF.md
# PCIe Ingress Region Guard with Snoop Control

This block sits between the PCIe side of a root complex and system memory. Every inbound memory request is compared against a small table of programmable address windows. A request that lies entirely inside at least one enabled window is allowed through. Any other request is refused with an Unsupported Request style error response, and a sticky status register keeps the address of the first refused request. For an allowed request, the NoSnoop attribute decides the path. With NoSnoop clear, a snoop request goes to the coherent fabric first, and the memory access waits for that snoop to be acknowledged. With NoSnoop set, the access goes straight to memory with no coherency action.

Inbound requests are handled one at a time, in arrival order. A second request is not accepted until the first has finished its memory handshake or its error handshake. On the outbound path, a plain control pin selects one of two modes. In force mode, NoSnoop is set on every outgoing request. In pass-through mode, each request keeps the NoSnoop value its requester supplied.

Every stream interface uses valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. Once a source raises valid, it keeps valid high and holds its payload steady until that transfer happens. A sink may hold ready low for any number of cycles. The configuration, mode and error-status pins are plain level signals.

Top module: `ingress_snoop_guard`

## Requirements
- R1: After reset, `ib_req_ready` is 1, `snp_valid`, `mem_valid` and `ur_valid` are 0, and `err_valid` is 0.
- R2: A request covers the byte range `ib_req_addr` to `ib_req_addr + ib_req_len_m1`. Entry i occupies bits [i*AW +: AW] of `cfg_base` and `cfg_limit`, and both bounds are inclusive. The request is allowed when some entry i has `cfg_en[i]` = 1 and its base <= first byte and last byte <= its limit. This includes a request that touches the base or the limit exactly.
- R3: A request is refused if its last byte falls outside every enabled window (partial overlap), if it matches only disabled entries, or if its last byte address wraps past the top of the AW-bit address space.
- R4: A refused request raises `ur_valid` with `ur_addr` equal to the request address in the cycle after it is accepted. It raises neither `snp_valid` nor `mem_valid`.
- R5: At a refusal, if `err_valid` is 0 or `err_clr` is 1, then `err_valid` is set to 1 and `err_addr` is loaded with the address. Later refusals leave `err_addr` unchanged. `err_clr` = 1 with no refusal in the same cycle clears `err_valid`.
- R6: An allowed request with `ib_req_ns` = 0 raises `snp_valid` with `snp_addr` equal to the request address in the cycle after it is accepted. `mem_valid` stays 0 until the snoop handshake completes, and rises in the cycle after that handshake.
- R7: An allowed request with `ib_req_ns` = 1 raises `mem_valid` in the cycle after it is accepted and never raises `snp_valid`. `mem_addr`, `mem_len_m1` and `mem_wr` equal the request's values.
- R8: Only one inbound request is in flight at a time. `ib_req_ready` is 0 from the cycle after acceptance until the cycle after the final memory or error handshake. Each output valid, together with its payload, stays unchanged while its ready is 0.
- R9: `ob_out_valid`, `ob_out_addr` and `ob_in_ready` pass straight through in the same cycle. When `ob_ns_force` = 1, `ob_out_ns` is 1. When `ob_ns_force` = 0, `ob_out_ns` equals `ob_in_ns`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | NREG*AW | Packed window base addresses, inclusive |
| cfg_limit | input | NREG*AW | Packed window limit addresses, inclusive |
| cfg_en | input | NREG | Per-window enable |
| ib_req_valid | input | 1 | Inbound request valid |
| ib_req_ready | output | 1 | Inbound request ready |
| ib_req_addr | input | AW | Inbound first byte address |
| ib_req_len_m1 | input | LW | Inbound length in bytes minus one |
| ib_req_wr | input | 1 | Inbound write (1) or read (0) |
| ib_req_ns | input | 1 | Inbound NoSnoop attribute |
| snp_valid | output | 1 | Snoop request valid |
| snp_ready | input | 1 | Snoop acknowledged by fabric |
| snp_addr | output | AW | Snoop address |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory access ready |
| mem_addr | output | AW | Memory access address |
| mem_len_m1 | output | LW | Memory access length minus one |
| mem_wr | output | 1 | Memory access write flag |
| ur_valid | output | 1 | Unsupported Request response valid |
| ur_ready | input | 1 | Unsupported Request response ready |
| ur_addr | output | AW | Address of the refused request |
| err_valid | output | 1 | Sticky refusal flag |
| err_addr | output | AW | Address of the first refused request |
| err_clr | input | 1 | Clears the sticky refusal flag |
| ob_ns_force | input | 1 | 1 = force NoSnoop set, 0 = pass-through |
| ob_in_valid | input | 1 | Outbound request valid from requester |
| ob_in_ready | output | 1 | Outbound ready toward requester |
| ob_in_addr | input | AW | Outbound request address |
| ob_in_ns | input | 1 | Requester's NoSnoop attribute |
| ob_out_valid | output | 1 | Outbound request valid toward the link |
| ob_out_ready | input | 1 | Outbound ready from the link |
| ob_out_addr | output | AW | Outbound address |
| ob_out_ns | output | 1 | NoSnoop attribute actually sent |

## Verification
The bench drives inputs on falling edges and samples on falling edges, so the result of the rising edge in between is already settled when it is read. An accepted request shows its first result one edge later: `snp_valid`, `mem_valid` or `ur_valid`, together with `err_valid`. On the snoop path, `mem_valid` appears exactly one edge after the snoop handshake, and `ib_req_ready` returns one edge after the final handshake. Before each handshake the bench holds the ready signal low for several cycles, so it can confirm that the outputs hold their values. The outbound path is combinational and is checked within the same cycle.

// File: rtl/isg_pkg.sv
package isg_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SNOOP = 2'd1,
    SEQ_MEM   = 2'd2,
    SEQ_UR    = 2'd3
  } seq_state_t;
endpackage

// File: rtl/isg_region_match.sv
module isg_region_match #(
  parameter int AW   = 32,
  parameter int LW   = 8,
  parameter int NREG = 4
) (
  input  logic [NREG*AW-1:0] base,
  input  logic [NREG*AW-1:0] limit,
  input  logic [NREG-1:0]    en,
  input  logic [AW-1:0]      addr,
  input  logic [LW-1:0]      len_m1,
  output logic               hit
);
  localparam int PADW = AW + 1 - LW;

  logic [AW:0]      last_ext;
  logic             wraps;
  logic [NREG-1:0]  entry_hit;

  // last byte address with one extra bit to detect wrap-around
  assign last_ext = {1'b0, addr} + {{PADW{1'b0}}, len_m1};
  assign wraps    = last_ext[AW];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
    logic [AW-1:0] lo, hi;
    assign lo = base[gi*AW +: AW];
    assign hi = limit[gi*AW +: AW];
    assign entry_hit[gi] = en[gi] && !wraps && (addr >= lo) && (last_ext[AW-1:0] <= hi);
  end

  assign hit = |entry_hit;
endmodule

// File: rtl/isg_inbound_seq.sv
module isg_inbound_seq
  import isg_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len_m1,
  input  logic          req_wr,
  input  logic          req_ns,
  input  logic          req_hit,
  output logic          snp_valid,
  input  logic          snp_ready,
  output logic [AW-1:0] snp_addr,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [LW-1:0] mem_len_m1,
  output logic          mem_wr,
  output logic          ur_valid,
  input  logic          ur_ready,
  output logic [AW-1:0] ur_addr,
  output logic          err_valid,
  output logic [AW-1:0] err_addr,
  input  logic          err_clr
);
  seq_state_t    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic          wr_q;
  logic          accept, refuse;

  assign req_ready = (state_q == SEQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign refuse    = accept && !req_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (accept) state_d = !req_hit ? SEQ_UR : (req_ns ? SEQ_MEM : SEQ_SNOOP);
      SEQ_SNOOP: if (snp_ready) state_d = SEQ_MEM;
      SEQ_MEM:   if (mem_ready) state_d = SEQ_IDLE;
      SEQ_UR:    if (ur_ready)  state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= req_addr;
        len_q  <= req_len_m1;
        wr_q   <= req_wr;
      end
    end
  end

  // sticky record of the first refused address
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_addr  <= '0;
    end else if (refuse && (!err_valid || err_clr)) begin
      err_valid <= 1'b1;
      err_addr  <= req_addr;
    end else if (err_clr) begin
      err_valid <= 1'b0;
    end
  end

  assign snp_valid  = (state_q == SEQ_SNOOP);
  assign snp_addr   = addr_q;
  assign mem_valid  = (state_q == SEQ_MEM);
  assign mem_addr   = addr_q;
  assign mem_len_m1 = len_q;
  assign mem_wr     = wr_q;
  assign ur_valid   = (state_q == SEQ_UR);
  assign ur_addr    = addr_q;
endmodule

// File: rtl/isg_ob_nosnoop.sv
module isg_ob_nosnoop #(
  parameter int AW = 32
) (
  input  logic          force_ns,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic          in_ns,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_ns
);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_addr  = in_addr;
  assign out_ns    = force_ns | in_ns;
endmodule

// File: rtl/ingress_snoop_guard.sv
module ingress_snoop_guard #(
  parameter int AW   = 32,
  parameter int LW   = 8,
  parameter int NREG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG*AW-1:0] cfg_base,
  input  logic [NREG*AW-1:0] cfg_limit,
  input  logic [NREG-1:0]   cfg_en,
  input  logic              ib_req_valid,
  output logic              ib_req_ready,
  input  logic [AW-1:0]     ib_req_addr,
  input  logic [LW-1:0]     ib_req_len_m1,
  input  logic              ib_req_wr,
  input  logic              ib_req_ns,
  output logic              snp_valid,
  input  logic              snp_ready,
  output logic [AW-1:0]     snp_addr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [AW-1:0]     mem_addr,
  output logic [LW-1:0]     mem_len_m1,
  output logic              mem_wr,
  output logic              ur_valid,
  input  logic              ur_ready,
  output logic [AW-1:0]     ur_addr,
  output logic              err_valid,
  output logic [AW-1:0]     err_addr,
  input  logic              err_clr,
  input  logic              ob_ns_force,
  input  logic              ob_in_valid,
  output logic              ob_in_ready,
  input  logic [AW-1:0]     ob_in_addr,
  input  logic              ob_in_ns,
  output logic              ob_out_valid,
  input  logic              ob_out_ready,
  output logic [AW-1:0]     ob_out_addr,
  output logic              ob_out_ns
);
  logic req_hit;

  isg_region_match #(.AW(AW), .LW(LW), .NREG(NREG)) u_match (
    .base(cfg_base), .limit(cfg_limit), .en(cfg_en),
    .addr(ib_req_addr), .len_m1(ib_req_len_m1), .hit(req_hit)
  );

  isg_inbound_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(ib_req_valid), .req_ready(ib_req_ready),
    .req_addr(ib_req_addr), .req_len_m1(ib_req_len_m1),
    .req_wr(ib_req_wr), .req_ns(ib_req_ns), .req_hit(req_hit),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_addr(snp_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_len_m1(mem_len_m1), .mem_wr(mem_wr),
    .ur_valid(ur_valid), .ur_ready(ur_ready), .ur_addr(ur_addr),
    .err_valid(err_valid), .err_addr(err_addr), .err_clr(err_clr)
  );

  isg_ob_nosnoop #(.AW(AW)) u_ob (
    .force_ns(ob_ns_force),
    .in_valid(ob_in_valid), .in_ready(ob_in_ready),
    .in_addr(ob_in_addr), .in_ns(ob_in_ns),
    .out_valid(ob_out_valid), .out_ready(ob_out_ready),
    .out_addr(ob_out_addr), .out_ns(ob_out_ns)
  );
endmodule

// File: rtl/isg_checker.sv
module isg_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ib_req_ready,
  input logic          snp_valid,
  input logic          snp_ready,
  input logic [AW-1:0] snp_addr,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          ur_valid,
  input logic          ur_ready,
  input logic [AW-1:0] ur_addr,
  input logic          err_valid,
  input logic [AW-1:0] err_addr,
  input logic          err_clr,
  input logic          ob_ns_force,
  input logic          ob_out_valid,
  input logic          ob_out_ns
);
  a_r8_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({snp_valid, mem_valid, ur_valid}));
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid || mem_valid || ur_valid) |-> !ib_req_ready);
  a_r6_snoop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_ready) |=> (snp_valid && $stable(snp_addr)));
  a_r6_mem_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_ready) |=> (mem_valid && $stable(mem_addr)));
  a_r8_mem_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
  a_r4_ur_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ur_valid && !ur_ready) |=> (ur_valid && $stable(ur_addr)));
  a_r5_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_clr) |=> (err_valid && $stable(err_addr)));
  a_r9_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_ns_force && ob_out_valid) |-> ob_out_ns);
endmodule

bind ingress_snoop_guard isg_checker #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ib_req_ready(ib_req_ready),
  .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_addr(snp_addr),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .ur_valid(ur_valid), .ur_ready(ur_ready), .ur_addr(ur_addr),
  .err_valid(err_valid), .err_addr(err_addr), .err_clr(err_clr),
  .ob_ns_force(ob_ns_force), .ob_out_valid(ob_out_valid), .ob_out_ns(ob_out_ns)
);

// File: tb/ingress_snoop_guard_tb_top.sv
`timescale 1ns/1ps
module ingress_snoop_guard_tb_top;
  localparam int AW = 32, LW = 8, NREG = 4;
  localparam int K_SNOOP = 0, K_DIRECT = 1, K_REFUSE = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NREG*AW-1:0] cfg_base, cfg_limit;
  logic [NREG-1:0] cfg_en;
  logic ib_req_valid = 0, ib_req_ready, ib_req_wr = 0, ib_req_ns = 0;
  logic [AW-1:0] ib_req_addr = '0;
  logic [LW-1:0] ib_req_len_m1 = '0;
  logic snp_valid, snp_ready = 0, mem_valid, mem_ready = 0, mem_wr;
  logic [AW-1:0] snp_addr, mem_addr, ur_addr, err_addr, ob_out_addr;
  logic [LW-1:0] mem_len_m1;
  logic ur_valid, ur_ready = 0, err_valid, err_clr = 0;
  logic ob_ns_force = 0, ob_in_valid = 0, ob_in_ready, ob_in_ns = 0;
  logic [AW-1:0] ob_in_addr = '0;
  logic ob_out_valid, ob_out_ready = 0, ob_out_ns;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ingress_snoop_guard #(.AW(AW), .LW(LW), .NREG(NREG)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_mem(input logic [AW-1:0] a, input logic [LW-1:0] l, input logic w);
    chk(mem_addr == a, "R7 mem_addr", mem_addr, a);
    chk(mem_len_m1 == l && mem_wr == w, "R7 mem_len/wr", {mem_len_m1, mem_wr}, {l, w});
    @(negedge clk);
    chk(mem_valid && mem_addr == a, "R8 mem held under stall", mem_valid, 1);
    mem_ready = 1;
    @(negedge clk);
    mem_ready = 0;
    chk(!mem_valid, "R8 mem drops after handshake", mem_valid, 0);
    chk(ib_req_ready, "R8 ready returns", ib_req_ready, 1);
  endtask

  task automatic do_inbound(input logic [AW-1:0] a, input logic [LW-1:0] l,
                            input logic ns, input logic w, input int kind);
    @(negedge clk);
    chk(ib_req_ready, "R8 idle ready", ib_req_ready, 1);
    ib_req_valid = 1; ib_req_addr = a; ib_req_len_m1 = l; ib_req_ns = ns; ib_req_wr = w;
    @(negedge clk);
    ib_req_valid = 0;
    chk(!ib_req_ready, "R8 busy after accept", ib_req_ready, 0);
    if (kind == K_SNOOP) begin
      chk(snp_valid && snp_addr == a, "R6 snoop raised", snp_addr, a);
      chk(!mem_valid && !ur_valid, "R2 allowed, no mem yet", {mem_valid, ur_valid}, 0);
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        chk(snp_valid && !mem_valid, "R6 mem waits for snoop ack", {snp_valid, mem_valid}, 2'b10);
      end
      snp_ready = 1;
      @(negedge clk);
      snp_ready = 0;
      chk(mem_valid && !snp_valid, "R6 mem after snoop ack", {snp_valid, mem_valid}, 2'b01);
      finish_mem(a, l, w);
    end else if (kind == K_DIRECT) begin
      chk(mem_valid && !snp_valid && !ur_valid, "R7 direct, no snoop",
          {snp_valid, mem_valid, ur_valid}, 3'b010);
      finish_mem(a, l, w);
    end else begin
      chk(ur_valid && ur_addr == a, "R4 ur raised", ur_addr, a);
      chk(!snp_valid && !mem_valid, "R3 refused, no snoop/mem", {snp_valid, mem_valid}, 0);
      @(negedge clk);
      chk(ur_valid && ur_addr == a, "R8 ur held under stall", ur_valid, 1);
      ur_ready = 1;
      @(negedge clk);
      ur_ready = 0;
      chk(!ur_valid && ib_req_ready, "R4 ur completes", {ur_valid, ib_req_ready}, 2'b01);
    end
  endtask

  task automatic check_err(input logic v, input logic [AW-1:0] a, input string req);
    chk(err_valid == v, req, err_valid, v);
    if (v) chk(err_addr == a, req, err_addr, a);
  endtask

  task automatic test_outbound();
    @(negedge clk);
    ob_in_valid = 1; ob_in_addr = 32'hCAFE_0000; ob_in_ns = 0; ob_out_ready = 1; ob_ns_force = 0;
    #1;
    chk(ob_out_ns == 0, "R9 pass-through ns=0", ob_out_ns, 0);
    chk(ob_out_valid && ob_in_ready && ob_out_addr == 32'hCAFE_0000, "R9 pass valid/ready/addr",
        ob_out_addr, 32'hCAFE_0000);
    ob_in_ns = 1; #1;
    chk(ob_out_ns == 1, "R9 pass-through ns=1", ob_out_ns, 1);
    ob_ns_force = 1; ob_in_ns = 0; ob_out_ready = 0; #1;
    chk(ob_out_ns == 1, "R9 force sets ns", ob_out_ns, 1);
    chk(!ob_in_ready, "R9 ready follows link", ob_in_ready, 0);
    @(negedge clk);
    ob_in_valid = 0; ob_ns_force = 0;
  endtask

  initial begin
    cfg_base  = {32'hFFFF_FF00, 32'h0000_4000, 32'h8000_0000, 32'h0000_1000};
    cfg_limit = {32'hFFFF_FFFF, 32'h0000_4FFF, 32'h8FFF_FFFF, 32'h0000_1FFF};
    cfg_en    = 4'b1011;  // entry 2 disabled
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ib_req_ready && !snp_valid && !mem_valid && !ur_valid && !err_valid, "R1 reset state",
        {ib_req_ready, snp_valid, mem_valid, ur_valid, err_valid}, 5'b10000);
    do_inbound(32'h0000_1000, 8'hFF, 0, 1, K_SNOOP);      // R2 at base, R6
    do_inbound(32'h0000_1F00, 8'hFF, 1, 0, K_DIRECT);     // R2 ends at limit, R7
    do_inbound(32'h8000_0040, 8'h3F, 0, 0, K_SNOOP);      // R6 second window
    do_inbound(32'h0000_1F80, 8'hFF, 0, 0, K_REFUSE);     // R3 partial overlap
    check_err(1, 32'h0000_1F80, "R5 first refusal captured");
    do_inbound(32'h0000_4000, 8'h0F, 1, 0, K_REFUSE);     // R3 disabled entry
    check_err(1, 32'h0000_1F80, "R5 first address kept");
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    check_err(0, '0, "R5 clear");
    do_inbound(32'hFFFF_FFF0, 8'h1F, 1, 0, K_REFUSE);     // R3 wrap
    check_err(1, 32'hFFFF_FFF0, "R5 recapture after clear");
    do_inbound(32'hFFFF_FFF0, 8'h0F, 1, 1, K_DIRECT);     // R2 top of space
    do_inbound(32'h0000_0800, 8'h00, 1, 0, K_REFUSE);     // R3 below all windows
    test_outbound();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule